// File: doc/BRIEF.md
# Four-Tap Sum-of-Products Filter Accumulator

This block is a multiply-accumulate datapath for small image filter kernels. It holds four signed data samples of 10 bits and four signed coefficients of 11 bits in input registers. Every cycle it multiplies each sample by its coefficient and adds the four products. The resulting sum either starts a fresh accumulation or is added to the running total in a 26-bit accumulator. A 16-bit window of that accumulator is then captured by an output register that can be frozen.

Each tap has a hold input, and one shared select decides which half of a held tap may still change. With this arrangement, a caller can stream new pixels through fixed weights or swap weights under fixed pixels without touching the other taps. The format input chooses between two number formats. In fractional mode the upper window is output, and the sum is rounded when an accumulation starts. In integer mode the low 16 bits are output with no rounding. An output-disable input gates the visible result to zero and drops the valid flag.

Top module: `sop4_filter`

## Requirements
- R1: A synchronous active-high `rst` clears every input register, the accumulator and the output register, so `result` reads 0 after reset.
- R2: When `tap_hold[n]` is 0, both the data and the coefficient of tap n load from their input slices on the clock edge. Tap n uses bits `[10n+9:10n]` of `data_in` and bits `[11n+10:11n]` of `coef_in`.
- R3: When `tap_hold[n]` is 1 and `hold_data_sel` is 0, the data of tap n loads and its coefficient keeps its value.
- R4: When `tap_hold[n]` is 1 and `hold_data_sel` is 1, the data of tap n keeps its value and its coefficient loads.
- R5: When `accum_cont` is 0, the accumulator discards its previous contents and takes the current four-product sum, plus the fractional rounding term of R7.
- R6: When `accum_cont` is 1, the current four-product sum is added to the accumulator with no rounding term.
- R7: With `int_mode` = 0 (fractional), `result` is accumulator bits [24:9]. When an accumulation starts, 2^8 is added, which is half of one output LSB.
- R8: With `int_mode` = 1 (integer), `result` is accumulator bits [15:0], and no rounding term is ever added.
- R9: While `out_freeze` is 1, the output register holds its value, and the accumulator keeps updating under `accum_cont`.
- R10: While `out_off` is 1, `result` is 0 and `result_valid` is 0, and the output register is left unchanged. While `out_off` is 0, `result_valid` is 1.
- R11: A sample captured on clock edge k appears on `result` after edge k+2, and not earlier.
- R12: Sums beyond the range of the output window or the accumulator wrap in two's complement and are never saturated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tap_hold | input | 4 | Per-tap hold request; 0 loads both data and coefficient |
| hold_data_sel | input | 1 | For held taps: 0 keeps the coefficient, 1 keeps the data |
| data_in | input | 40 | Four packed signed 10-bit samples, tap 0 in the low bits |
| coef_in | input | 44 | Four packed signed 11-bit coefficients, tap 0 in the low bits |
| accum_cont | input | 1 | 1 adds to the running total, 0 starts a new accumulation |
| int_mode | input | 1 | 1 selects integer format, 0 selects fractional format |
| out_freeze | input | 1 | 1 holds the output register |
| out_off | input | 1 | 1 forces the result to zero and clears the valid flag |
| result | output | 16 | Selected accumulator window |
| result_valid | output | 1 | High while the result is presented |

## Verification
The hardest case to reach from the ports is a frozen output register while the accumulator keeps running underneath it. That hidden state only shows up once the freeze is released, so the bench builds a known total, freezes the output for several accumulating cycles, and checks that the first value after release is the larger total. Held-operand behaviour likewise only shows through products, so the bench sweeps every combination of hold pattern, select, format, accumulate, freeze and disable against a cycle model.

// File: rtl/sop4_pkg.sv
package sop4_pkg;

    localparam int NTAP       = 4;
    localparam int DW         = 10;
    localparam int CW         = 11;
    localparam int AW         = 26;
    localparam int OW         = 16;
    localparam int FRAC_SHIFT = 9;

    localparam int PW = DW + CW;
    localparam int SW = PW + $clog2(NTAP);

    typedef logic signed [DW-1:0] data_t;
    typedef logic signed [CW-1:0] coef_t;
    typedef logic signed [PW-1:0] prod_t;
    typedef logic signed [SW-1:0] sum_t;
    typedef logic signed [AW-1:0] acc_t;
    typedef logic signed [OW-1:0] word_t;

    typedef enum logic { FMT_FRAC = 1'b0, FMT_INT = 1'b1 } fmt_e;

    typedef enum logic [1:0] {
        LD_BOTH = 2'd0,
        LD_DATA = 2'd1,
        LD_COEF = 2'd2
    } load_e;

    typedef struct packed {
        acc_t acc;
        fmt_e fmt;
    } acc_stage_t;

    function automatic load_e decode_load(input logic hold, input logic keep_data);
        if (!hold)          return LD_BOTH;
        else if (keep_data) return LD_COEF;
        else                return LD_DATA;
    endfunction

    function automatic acc_t round_bias(input fmt_e f);
        if (f == FMT_FRAC) return acc_t'(1 << (FRAC_SHIFT - 1));
        else               return '0;
    endfunction

    function automatic word_t pick_window(input acc_stage_t s);
        if (s.fmt == FMT_INT) return s.acc[OW-1:0];
        else                  return s.acc[FRAC_SHIFT +: OW];
    endfunction

endpackage

// File: rtl/sop4_tap_bank.sv
module sop4_tap_bank
    import sop4_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NTAP-1:0]      tap_hold,
    input  logic                 hold_data_sel,
    input  logic [NTAP*DW-1:0]   data_in,
    input  logic [NTAP*CW-1:0]   coef_in,
    output logic [NTAP*DW-1:0]   data_q,
    output logic [NTAP*CW-1:0]   coef_q
);

    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        load_e mode;
        assign mode = decode_load(tap_hold[t], hold_data_sel);

        always_ff @(posedge clk) begin
            if (rst) begin
                data_q[t*DW +: DW] <= '0;
                coef_q[t*CW +: CW] <= '0;
            end else begin
                case (mode)
                    LD_BOTH: begin
                        data_q[t*DW +: DW] <= data_in[t*DW +: DW];
                        coef_q[t*CW +: CW] <= coef_in[t*CW +: CW];
                    end
                    LD_DATA: data_q[t*DW +: DW] <= data_in[t*DW +: DW];
                    LD_COEF: coef_q[t*CW +: CW] <= coef_in[t*CW +: CW];
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sop4_mac.sv
module sop4_mac
    import sop4_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NTAP*DW-1:0]   data_q,
    input  logic [NTAP*CW-1:0]   coef_q,
    input  logic                 accum_cont,
    input  logic                 int_mode,
    output acc_stage_t           stage_q
);

    prod_t prod [NTAP];
    sum_t  sop_sum;
    acc_t  sum_ext;
    acc_t  acc_nxt;
    fmt_e  fmt_now;

    for (genvar t = 0; t < NTAP; t++) begin : g_mul
        data_t dv;
        coef_t cv;
        assign dv = data_q[t*DW +: DW];
        assign cv = coef_q[t*CW +: CW];
        assign prod[t] = PW'(dv) * PW'(cv);
    end

    always_comb begin
        sop_sum = '0;
        for (int t = 0; t < NTAP; t++) begin
            sop_sum = sop_sum + SW'(prod[t]);
        end
    end

    assign sum_ext = AW'(sop_sum);
    assign fmt_now = fmt_e'(int_mode);

    always_comb begin
        if (accum_cont) acc_nxt = stage_q.acc + sum_ext;
        else            acc_nxt = sum_ext + round_bias(fmt_now);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q.acc <= acc_nxt;
            stage_q.fmt <= fmt_now;
        end
    end

endmodule

// File: rtl/sop4_out_stage.sv
module sop4_out_stage
    import sop4_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            out_freeze,
    input  logic            out_off,
    input  acc_stage_t      stage_q,
    output logic [OW-1:0]   result,
    output logic            result_valid
);

    word_t out_q;

    always_ff @(posedge clk) begin
        if (rst)             out_q <= '0;
        else if (!out_freeze) out_q <= pick_window(stage_q);
    end

    assign result       = out_off ? '0 : out_q;
    assign result_valid = !out_off;

endmodule

// File: rtl/sop4_filter.sv
module sop4_filter
    import sop4_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NTAP-1:0]      tap_hold,
    input  logic                 hold_data_sel,
    input  logic [NTAP*DW-1:0]   data_in,
    input  logic [NTAP*CW-1:0]   coef_in,
    input  logic                 accum_cont,
    input  logic                 int_mode,
    input  logic                 out_freeze,
    input  logic                 out_off,
    output logic [OW-1:0]        result,
    output logic                 result_valid
);

    logic [NTAP*DW-1:0] data_q;
    logic [NTAP*CW-1:0] coef_q;
    acc_stage_t         stage_q;

    sop4_tap_bank u_taps (
        .clk          (clk),
        .rst          (rst),
        .tap_hold     (tap_hold),
        .hold_data_sel(hold_data_sel),
        .data_in      (data_in),
        .coef_in      (coef_in),
        .data_q       (data_q),
        .coef_q       (coef_q)
    );

    sop4_mac u_mac (
        .clk       (clk),
        .rst       (rst),
        .data_q    (data_q),
        .coef_q    (coef_q),
        .accum_cont(accum_cont),
        .int_mode  (int_mode),
        .stage_q   (stage_q)
    );

    sop4_out_stage u_out (
        .clk         (clk),
        .rst         (rst),
        .out_freeze  (out_freeze),
        .out_off     (out_off),
        .stage_q     (stage_q),
        .result      (result),
        .result_valid(result_valid)
    );

endmodule

// File: rtl/sop4_filter_chk.sv
module sop4_filter_chk
    import sop4_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [NTAP-1:0]      tap_hold,
    input logic                 hold_data_sel,
    input logic [NTAP*DW-1:0]   data_in,
    input logic [NTAP*CW-1:0]   coef_in,
    input logic                 out_freeze,
    input logic                 out_off,
    input logic [OW-1:0]        result,
    input logic                 result_valid,
    input logic [NTAP*DW-1:0]   data_q,
    input logic [NTAP*CW-1:0]   coef_q
);

    logic live_q;
    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (result == '0));

    p_off_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> (result == '0));

    p_freeze_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(out_freeze) && $past(!out_off) && !out_off)
            |-> (result == $past(result)));

    for (genvar t = 0; t < NTAP; t++) begin : g_chk
        p_both_load_r2: assert property (@(posedge clk) disable iff (rst)
            (live_q && $past(!tap_hold[t]))
                |-> (data_q[t*DW +: DW] == $past(data_in[t*DW +: DW]) &&
                     coef_q[t*CW +: CW] == $past(coef_in[t*CW +: CW])));

        p_coef_keep_r3: assert property (@(posedge clk) disable iff (rst)
            (live_q && $past(tap_hold[t] && !hold_data_sel))
                |-> (coef_q[t*CW +: CW] == $past(coef_q[t*CW +: CW]) &&
                     data_q[t*DW +: DW] == $past(data_in[t*DW +: DW])));

        p_data_keep_r4: assert property (@(posedge clk) disable iff (rst)
            (live_q && $past(tap_hold[t] && hold_data_sel))
                |-> (data_q[t*DW +: DW] == $past(data_q[t*DW +: DW]) &&
                     coef_q[t*CW +: CW] == $past(coef_in[t*CW +: CW])));
    end

endmodule

bind sop4_filter sop4_filter_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .tap_hold     (tap_hold),
    .hold_data_sel(hold_data_sel),
    .data_in      (data_in),
    .coef_in      (coef_in),
    .out_freeze   (out_freeze),
    .out_off      (out_off),
    .result       (result),
    .result_valid (result_valid),
    .data_q       (data_q),
    .coef_q       (coef_q)
);

// File: tb/sop4_filter_tb_top.sv
module sop4_filter_tb_top;
    import sop4_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NTAP-1:0]    tap_hold = '0;
    logic               hold_data_sel = 1'b0;
    logic [NTAP*DW-1:0] data_in = '0;
    logic [NTAP*CW-1:0] coef_in = '0;
    logic               accum_cont = 1'b0;
    logic               int_mode = 1'b1;
    logic               out_freeze = 1'b0;
    logic               out_off = 1'b0;
    logic [OW-1:0]      result;
    logic               result_valid;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sop4_filter dut_i (
        .clk(clk), .rst(rst), .tap_hold(tap_hold), .hold_data_sel(hold_data_sel),
        .data_in(data_in), .coef_in(coef_in), .accum_cont(accum_cont),
        .int_mode(int_mode), .out_freeze(out_freeze), .out_off(out_off),
        .result(result), .result_valid(result_valid)
    );

    // Cycle model written from the requirements
    logic signed [DW-1:0] md [NTAP];
    logic signed [CW-1:0] mc [NTAP];
    logic signed [AW-1:0] macc;
    logic                 mfmt;
    logic [OW-1:0]        mout;

    function automatic int model_sop();
        int s = 0;
        for (int k = 0; k < NTAP; k++) s += int'(md[k]) * int'(mc[k]);
        return s;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NTAP; k++) begin md[k] <= '0; mc[k] <= '0; end
            macc <= '0; mfmt <= 1'b0; mout <= '0;
        end else begin
            if (!out_freeze) mout <= mfmt ? macc[15:0] : macc[24:9];
            macc <= accum_cont ? macc + AW'(model_sop())
                               : AW'(model_sop()) + (int_mode ? 26'sd0 : 26'sd256);
            mfmt <= int_mode;
            for (int k = 0; k < NTAP; k++) begin
                if (!tap_hold[k]) begin
                    md[k] <= data_in[k*DW +: DW]; mc[k] <= coef_in[k*CW +: CW];
                end else if (!hold_data_sel) md[k] <= data_in[k*DW +: DW];
                else                         mc[k] <= coef_in[k*CW +: CW];
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fill(input logic [DW-1:0] d, input logic [CW-1:0] c);
        data_in = {NTAP{d}};
        coef_in = {NTAP{c}};
    endtask

    initial begin
        edges(3);
        check("R1 result in reset", 32'(result), 32'h0);
        rst = 1'b0;
        edges(1);
        check("R1 result after reset", 32'(result), 32'h0);
        check("R10 valid with output enabled", 32'(result_valid), 32'h1);

        // R11 and R2: integer, restart each cycle, 4*3*5 = 60
        int_mode = 1'b1; accum_cont = 1'b0; tap_hold = '0; fill(10'd3, 11'd5);
        edges(1);
        check("R11 not after one edge", 32'(result), 32'h0);
        edges(1);
        check("R11 not after two edges", 32'(result), 32'h0);
        edges(1);
        check("R11 R2 value after capture plus two", 32'(result), 32'd60);

        // R3: coefficient stays 5, data becomes 4 -> 80
        tap_hold = '1; hold_data_sel = 1'b0; fill(10'd4, 11'd9);
        edges(3);
        check("R3 coefficient kept data loaded", 32'(result), 32'd80);

        // R4: data stays 4, coefficient becomes -2 -> -32
        hold_data_sel = 1'b1; fill(10'd7, 11'h7FE);
        edges(3);
        check("R4 data kept coefficient loaded", 32'(result), 32'h0000FFE0);

        // R6: three accumulating edges -> -96
        accum_cont = 1'b1;
        edges(3);
        check("R6 running total", 32'(result), 32'h0000FFA0);

        // R9: frozen for three edges while the total grows
        out_freeze = 1'b1;
        edges(3);
        check("R9 output frozen", 32'(result), 32'h0000FFA0);
        out_freeze = 1'b0; accum_cont = 1'b0;
        edges(1);
        check("R9 accumulation continued under freeze", 32'(result), 32'h0000FF20);
        edges(1);
        check("R5 restart discards total", 32'(result), 32'h0000FFE0);

        // R10
        out_off = 1'b1;
        edges(1);
        check("R10 result gated", 32'(result), 32'h0);
        check("R10 valid low", 32'(result_valid), 32'h0);
        out_off = 1'b0;
        #1;
        check("R10 register untouched", 32'(result), 32'h0000FFE0);
        edges(1);

        // R7 / R8: only tap 0 nonzero
        tap_hold = '0; int_mode = 1'b0;
        data_in = '0; data_in[DW-1:0] = 10'd1;
        coef_in = '0; coef_in[CW-1:0] = 11'd256;
        edges(3);
        check("R7 half LSB rounds up", 32'(result), 32'h1);
        coef_in[CW-1:0] = 11'd255;
        edges(3);
        check("R7 below half truncates", 32'(result), 32'h0);
        int_mode = 1'b1; coef_in[CW-1:0] = 11'd256;
        edges(3);
        check("R8 integer window no rounding", 32'(result), 32'd256);

        // R12: extremes wrap
        fill(10'd511, 11'd1023);
        edges(3);
        check("R12 integer wrap", 32'(result), 32'h0000E804);
        int_mode = 1'b0;
        edges(3);
        check("R12 R7 fractional window", 32'(result), 32'h00000FF4);
        int_mode = 1'b1; fill(10'h200, 11'h400);
        edges(3);
        check("R12 most negative operands", 32'(result), 32'h0);

        // Sweep every control combination against the model
        for (int rep = 0; rep < 8; rep++) begin
            for (int combo = 0; combo < 512; combo++) begin
                tap_hold      = combo[3:0];
                hold_data_sel = combo[4];
                accum_cont    = combo[5];
                int_mode      = combo[6];
                out_freeze    = combo[7];
                out_off       = combo[8];
                for (int k = 0; k < NTAP; k++) begin
                    data_in[k*DW +: DW] = DW'($urandom);
                    coef_in[k*CW +: CW] = CW'($urandom);
                end
                edges(1);
                check("R2 R3 R4 R5 R6 R7 R8 R9 R12 sweep result",
                      32'(result), 32'(out_off ? 16'h0 : mout));
                check("R10 sweep valid", 32'(result_valid), 32'(!out_off));
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule